// File: doc/BRIEF.md
# Rolling Activate Window Limiter

One instance of this block serves one rank of a DRAM channel. It takes one activate event per clock, each with a timestamp. From these it keeps, for every bank of the rank, the earliest time at which the next activate may be issued. Two rules set these times. The first is a fixed minimum gap after any activate in the rank. The second allows no more than a set number of activates inside a sliding time window. The block remembers the timestamps of the most recent activates in a short shift history and reads the oldest one to apply the window rule.

Every new bound is merged into each bank's current value by taking the maximum, so a constraint that is already in force is never relaxed. The history is also checked before each update. If an activate arrives while the window is still full, a sticky violation flag is raised. A scheduler reads the per-bank times, and a testbench watches the flag. A history depth of zero turns the window rule and the violation check off.

All banks receive the same updates. The activate therefore carries no bank index, and every output lane tracks the same rank-wide bound.

Top module: `act_window_limiter`

## Requirements
- R1: After a synchronous reset, every bank's allowed time is 0, the violation flag is low and every history slot is empty (0).
- R2: On an activate with timestamp T, every bank's allowed time becomes max(previous value, T + gap), where gap is the `cfg_gap` value. The new value is visible on the first clock after the strobe.
- R3: A merge never lowers an allowed time. A candidate bound smaller than the present value leaves the value unchanged.
- R4: Every activate shifts the history: T enters at the newest slot and the others move one place older. With window depth D = `cfg_depth` (1..MAX_DEPTH), the oldest slot is slot D-1 after the shift. If that slot is nonzero and T minus it is less than `cfg_window`, every bank's allowed time also merges with (oldest + `cfg_window`). With D = 1, the oldest slot after the shift is T itself.
- R5: A history slot holding 0 is empty. It never applies the window bound and never raises the violation flag.
- R6: Before the shift, if slot D-1 is nonzero and T minus it is less than `cfg_window`, `viol` rises on the next clock and stays high until reset.
- R7: With `cfg_depth` = 0, neither the window bound nor the violation check takes effect. Only the gap rule applies.
- R8: In a cycle with no activate strobe, no allowed time and no flag changes.
- R9: A `cfg_depth` value above MAX_DEPTH acts as MAX_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | Activate strobe, one per cycle at most |
| act_ts | input | TS_W | Timestamp of the activate |
| cfg_gap | input | TS_W | Minimum spacing between any two activates in the rank |
| cfg_window | input | TS_W | Length of the sliding activate window |
| cfg_depth | input | DEP_W | Activates allowed per window; 0 disables the window |
| act_allowed | output | NUM_BANKS*TS_W | Earliest activate time per bank, bank b at bits [b*TS_W +: TS_W] |
| viol | output | 1 | Sticky window violation flag |

## Verification
Every result is registered. Both the per-bank allowed times and the violation flag for an activate strobed at a rising edge appear at that edge and hold until the next strobe. The driver raises the strobe for one cycle between falling edges and pushes the values a reference model predicts into a queue. The monitor records at the rising edge that a strobe was taken, then pops the queue and compares all lanes and the flag at the following falling edge, exactly one cycle after the stimulus. Idle stretches are checked against the last prediction after several strobe-free cycles.

// File: rtl/alw_pkg.sv
package alw_pkg;
  localparam int DEF_BANKS = 8;
  localparam int DEF_TS_W  = 32;
  localparam int DEF_DEPTH = 4;
endpackage

// File: rtl/alw_history.sv
// Shift history of recent activate timestamps, with views of the oldest
// slot both before and after the pending shift.
module alw_history #(
  parameter int DEPTH = 4,
  parameter int TS_W  = 32,
  parameter int DEP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [TS_W-1:0]  ts_in,
  input  logic [DEP_W-1:0] depth_sel,
  output logic [TS_W-1:0]  oldest_pre,
  output logic [TS_W-1:0]  oldest_post
);
  logic [TS_W-1:0] slot [DEPTH];
  logic [TS_W-1:0] nxt  [DEPTH];

  assign nxt[0] = ts_in;
  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_shift
      assign nxt[g] = slot[g-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (shift_en) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= nxt[i];
    end
  end

  always_comb begin
    oldest_pre  = '0;
    oldest_post = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(depth_sel) == i + 1) begin
        oldest_pre  = slot[i];
        oldest_post = nxt[i];
      end
    end
  end
endmodule

// File: rtl/alw_window_eval.sv
// Combinational evaluation of the gap bound, the window bound and the
// early-activate condition.
module alw_window_eval #(
  parameter int TS_W = 32
) (
  input  logic            win_en,
  input  logic [TS_W-1:0] ts,
  input  logic [TS_W-1:0] gap,
  input  logic [TS_W-1:0] window,
  input  logic [TS_W-1:0] oldest_pre,
  input  logic [TS_W-1:0] oldest_post,
  output logic [TS_W-1:0] gap_bound,
  output logic            win_hit,
  output logic [TS_W-1:0] win_bound,
  output logic            early
);
  logic [TS_W-1:0] age_pre;
  logic [TS_W-1:0] age_post;

  always_comb begin
    age_pre   = ts - oldest_pre;
    age_post  = ts - oldest_post;
    gap_bound = ts + gap;
    win_bound = oldest_post + window;
    early     = win_en && (oldest_pre  != '0) && (age_pre  < window);
    win_hit   = win_en && (oldest_post != '0) && (age_post < window);
  end
endmodule

// File: rtl/alw_bank_reg.sv
// One bank's earliest-activate register, max-merged on every update.
module alw_bank_reg #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic [TS_W-1:0] bound_a,
  input  logic            bound_b_en,
  input  logic [TS_W-1:0] bound_b,
  output logic [TS_W-1:0] value
);
  logic [TS_W-1:0] merged;

  always_comb begin
    merged = value;
    if (bound_a > merged) merged = bound_a;
    if (bound_b_en && (bound_b > merged)) merged = bound_b;
  end

  always_ff @(posedge clk) begin
    if (rst)      value <= '0;
    else if (upd) value <= merged;
  end
endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter
  import alw_pkg::*;
#(
  parameter int NUM_BANKS = DEF_BANKS,
  parameter int TS_W      = DEF_TS_W,
  parameter int MAX_DEPTH = DEF_DEPTH,
  localparam int DEP_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      act_valid,
  input  logic [TS_W-1:0]           act_ts,
  input  logic [TS_W-1:0]           cfg_gap,
  input  logic [TS_W-1:0]           cfg_window,
  input  logic [DEP_W-1:0]          cfg_depth,
  output logic [NUM_BANKS*TS_W-1:0] act_allowed,
  output logic                      viol
);
  logic [DEP_W-1:0] depth_eff;
  logic [TS_W-1:0]  oldest_pre, oldest_post;
  logic [TS_W-1:0]  gap_bound, win_bound;
  logic             win_hit, early;
  logic             win_en;

  assign depth_eff = (cfg_depth > DEP_W'(MAX_DEPTH)) ? DEP_W'(MAX_DEPTH) : cfg_depth;
  assign win_en    = (depth_eff != '0);

  alw_history #(.DEPTH(MAX_DEPTH), .TS_W(TS_W), .DEP_W(DEP_W)) u_hist (
    .clk         (clk),
    .rst         (rst),
    .shift_en    (act_valid),
    .ts_in       (act_ts),
    .depth_sel   (depth_eff),
    .oldest_pre  (oldest_pre),
    .oldest_post (oldest_post)
  );

  alw_window_eval #(.TS_W(TS_W)) u_eval (
    .win_en      (win_en),
    .ts          (act_ts),
    .gap         (cfg_gap),
    .window      (cfg_window),
    .oldest_pre  (oldest_pre),
    .oldest_post (oldest_post),
    .gap_bound   (gap_bound),
    .win_hit     (win_hit),
    .win_bound   (win_bound),
    .early       (early)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      alw_bank_reg #(.TS_W(TS_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .upd        (act_valid),
        .bound_a    (gap_bound),
        .bound_b_en (win_hit),
        .bound_b    (win_bound),
        .value      (act_allowed[b*TS_W +: TS_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                     viol <= 1'b0;
    else if (act_valid && early) viol <= 1'b1;
  end
endmodule

// File: rtl/alw_checker.sv
module alw_checker #(
  parameter int NUM_BANKS = 8,
  parameter int TS_W      = 32,
  parameter int DEP_W     = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      act_valid,
  input logic [TS_W-1:0]           act_ts,
  input logic [TS_W-1:0]           cfg_gap,
  input logic [DEP_W-1:0]          cfg_depth,
  input logic [NUM_BANKS*TS_W-1:0] act_allowed,
  input logic                      viol
);
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      p_no_loosen_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> act_allowed[b*TS_W +: TS_W] >= $past(act_allowed[b*TS_W +: TS_W]));
      p_gap_bound_r2: assert property (@(posedge clk) disable iff (rst)
        act_valid |=> act_allowed[b*TS_W +: TS_W] >= $past(act_ts) + $past(cfg_gap));
    end
  endgenerate

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !act_valid |=> $stable(act_allowed) && $stable(viol));

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    viol |=> viol);

  p_off_noviol_r7: assert property (@(posedge clk) disable iff (rst)
    (act_valid && cfg_depth == '0 && !viol) |=> !viol);
endmodule

bind act_window_limiter alw_checker #(
  .NUM_BANKS(NUM_BANKS), .TS_W(TS_W), .DEP_W(DEP_W)
) u_chk (
  .clk(clk), .rst(rst), .act_valid(act_valid), .act_ts(act_ts),
  .cfg_gap(cfg_gap), .cfg_depth(cfg_depth),
  .act_allowed(act_allowed), .viol(viol)
);

// File: tb/act_window_limiter_tb.sv
module act_window_limiter_tb;
  localparam int NB = 8;
  localparam int TW = 32;
  localparam int MD = 4;
  localparam int DW = $clog2(MD + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           act_valid = 1'b0;
  logic [TW-1:0]  act_ts = '0;
  logic [TW-1:0]  cfg_gap = '0;
  logic [TW-1:0]  cfg_window = '0;
  logic [DW-1:0]  cfg_depth = '0;
  logic [NB*TW-1:0] act_allowed;
  logic           viol;

  int checks = 0;
  int errors = 0;

  logic [TW-1:0] m_hist [MD];
  logic [TW-1:0] m_allowed;
  logic          m_viol;

  logic [TW-1:0] q_val [$];
  logic          q_viol [$];
  string         q_tag [$];
  logic          fired = 1'b0;

  always #4 clk = ~clk;

  act_window_limiter #(.NUM_BANKS(NB), .TS_W(TW), .MAX_DEPTH(MD)) u_dut (
    .clk(clk), .rst(rst), .act_valid(act_valid), .act_ts(act_ts),
    .cfg_gap(cfg_gap), .cfg_window(cfg_window), .cfg_depth(cfg_depth),
    .act_allowed(act_allowed), .viol(viol)
  );

  task automatic compare_all(input logic [TW-1:0] ev, input logic evl, input string tag);
    for (int b = 0; b < NB; b++) begin
      checks++;
      if (act_allowed[b*TW +: TW] !== ev) begin
        errors++;
        $display("FAIL %s bank %0d allowed actual %0d expected %0d", tag, b, act_allowed[b*TW +: TW], ev);
      end
    end
    checks++;
    if (viol !== evl) begin
      errors++;
      $display("FAIL %s viol actual %0b expected %0b", tag, viol, evl);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < MD; i++) m_hist[i] = '0;
    m_allowed = '0;
    m_viol = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare_all('0, 1'b0, "R1 reset");
  endtask

  // Reference model: window depth clamped, pre-shift check, shift, post-shift bound.
  task automatic act(input logic [TW-1:0] ts, input string tag);
    int d;
    logic [TW-1:0] old;
    @(negedge clk);
    d = (int'(cfg_depth) > MD) ? MD : int'(cfg_depth);
    if (d != 0) begin
      old = m_hist[d-1];
      if (old != 0 && (ts - old) < cfg_window) m_viol = 1'b1;
    end
    for (int i = MD - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = ts;
    if (ts + cfg_gap > m_allowed) m_allowed = ts + cfg_gap;
    if (d != 0) begin
      old = m_hist[d-1];
      if (old != 0 && (ts - old) < cfg_window && old + cfg_window > m_allowed)
        m_allowed = old + cfg_window;
    end
    q_val.push_back(m_allowed);
    q_viol.push_back(m_viol);
    q_tag.push_back(tag);
    act_valid = 1'b1;
    act_ts = ts;
    @(negedge clk);
    act_valid = 1'b0;
  endtask

  always @(posedge clk) fired <= act_valid;

  always @(negedge clk) begin
    if (fired && q_val.size() > 0) begin
      logic [TW-1:0] ev;
      logic evl;
      string tg;
      ev = q_val.pop_front();
      evl = q_viol.pop_front();
      tg = q_tag.pop_front();
      compare_all(ev, evl, tg);
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    cfg_gap = 4; cfg_window = 30; cfg_depth = 4;
    do_reset();
    act(100, "R2 first gap");          // 104
    act(105, "R5 empty slot");         // 109
    act(110, "R5 empty slot");         // 114
    act(115, "R4 window bound");       // 130
    act(120, "R6 violation");          // 135, viol
    repeat (6) @(negedge clk);
    compare_all(m_allowed, m_viol, "R8 idle hold");
    act(200, "R6 sticky");             // window clear, viol stays
    repeat (3) @(negedge clk);

    cfg_depth = 0; cfg_gap = 40;
    do_reset();
    act(100, "R7 depth zero");         // 140
    cfg_gap = 2;
    act(110, "R3 no loosen");          // stays 140
    act(112, "R7 no window");
    act(113, "R7 no violation");
    repeat (3) @(negedge clk);

    cfg_depth = 7; cfg_gap = 4; cfg_window = 30;
    do_reset();
    act(10, "R9 clamp");
    act(12, "R9 clamp");
    act(14, "R9 clamp");
    act(16, "R9 clamp window");        // 40
    act(18, "R9 clamp violation");
    repeat (3) @(negedge clk);

    cfg_depth = 1;
    do_reset();
    act(50, "R4 depth one");           // 80
    act(60, "R6 depth one");           // viol, 90
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule